// File: doc/BRIEF.md
# Bidirectional Latched Bus Transceiver

This block connects two 16-bit ports, A and B, and moves data between them in either direction. The 16 bits form two 8-bit sections, and each section has its own control set. Every section has one bank of storage for the A-to-B path and one for the B-to-A path. Each path has three active-low controls: a chip enable, a latch enable and an output enable. When the chip enable and the latch enable are both low, the path is transparent and the far port follows the near port. When the path closes, it freezes its data. The output enable, qualified by the chip enable, decides whether the far port is driven.

The bidirectional pins are split into an input vector, an output vector and a per-bit drive-enable vector for each port, so the block has no internal tristate nets. A pad ring or the bus fabric combines these vectors into real pins. The latch is modelled in the synchronous domain. While the path is open, the storage takes a copy of the input on every rising clock edge, and the output passes the live input through with no register in the path. While the path is closed, the output shows the last copy taken. A per-section contention flag goes high whenever both directions of that section drive at the same time.

Top module: `xcvr_latched`

## Requirements
- R1: Each section owns bits [8k+7:8k] of every data vector and is controlled only by bit k of each control vector. The controls of one section have no effect on the other section's bits.
- R2: For each section, the A-to-B drive-enable bits (`b_oe`) are all 1 when `ab_chip_en_n` and `ab_out_en_n` are both 0 for that section. Otherwise they are all 0.
- R3: While `ab_chip_en_n`=0, `ab_latch_en_n`=0 and the path is driving, `b_out` equals `a_in` for that section in the same cycle, with no clock delay.
- R4: While the A-to-B path is open, its storage takes `a_in` at every rising clock edge. After `ab_latch_en_n` goes high, `b_out` shows the value taken at the last edge at which the path was open.
- R5: A rise of `ab_chip_en_n` while `ab_latch_en_n` stays low also closes the path, and the stored value is held.
- R6: With `ab_out_en_n`=1 and the path open, the storage still captures `a_in`. That data appears on `b_out` once the output is enabled.
- R7: While `ab_chip_en_n`=1, changes on `a_in` do not alter the stored A-to-B value, whatever the value of `ab_latch_en_n`.
- R8: Every `a_out`/`b_out` bit whose drive-enable bit is 0 reads 0.
- R9: The B-to-A path behaves the same way as the A-to-B path, from `b_in` to `a_out`/`a_oe`, under `ba_chip_en_n`, `ba_latch_en_n` and `ba_out_en_n`.
- R10: `contention[k]` is 1 exactly when both directions of section k are driving.
- R11: A low `rst_n` clears all stored data to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at which open paths take their copy |
| rst_n | input | 1 | Active-low synchronous reset of stored data |
| a_in | input | 16 | Data arriving on port A |
| a_out | output | 16 | Data to drive onto port A |
| a_oe | output | 16 | Per-bit drive enable for port A |
| b_in | input | 16 | Data arriving on port B |
| b_out | output | 16 | Data to drive onto port B |
| b_oe | output | 16 | Per-bit drive enable for port B |
| ab_chip_en_n | input | 2 | A-to-B chip enable per section, active low |
| ab_latch_en_n | input | 2 | A-to-B latch enable per section, active low |
| ab_out_en_n | input | 2 | A-to-B output enable per section, active low |
| ba_chip_en_n | input | 2 | B-to-A chip enable per section, active low |
| ba_latch_en_n | input | 2 | B-to-A latch enable per section, active low |
| ba_out_en_n | input | 2 | B-to-A output enable per section, active low |
| contention | output | 2 | Per section, both directions are driving |

## Verification
A stored word that captured the wrong value, or kept capturing after it closed, is not visible while the path is transparent. It shows on the far port in the first cycle after the latch enable or the chip enable rises. For this reason the tests always close a path and then compare the held value against the input sampled at the last open edge. A gate that ignores the chip enable leaks a later input into storage, and this appears only when the path is re-enabled with its latch enable high. A cross-wired section control appears immediately as a wrong byte in the other half of the word.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
    localparam int unsigned SECT_BITS = 8;
    localparam int unsigned SECTIONS  = 2;
    localparam int unsigned BUS_BITS  = SECT_BITS * SECTIONS;

    typedef struct packed {
        logic [SECT_BITS-1:0] store;
    } lane_state_t;
endpackage

// File: rtl/xcvr_lane.sv
module xcvr_lane #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    input  logic             chip_en_n,
    input  logic             latch_en_n,
    input  logic             out_en_n,
    output logic [WIDTH-1:0] dout,
    output logic [WIDTH-1:0] drive_en,
    output logic             driving
);
    typedef struct packed {
        logic [WIDTH-1:0] store;
    } state_t;

    state_t st_d, st_q;
    logic   open_w;
    logic   drv_w;
    logic [WIDTH-1:0] view_w;

    always_comb begin
        st_d   = st_q;
        open_w = ~chip_en_n & ~latch_en_n;
        drv_w  = ~chip_en_n & ~out_en_n;
        if (open_w) begin
            st_d.store = din;
        end
        view_w = open_w ? din : st_q.store;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout     = drv_w ? view_w : '0;
    assign drive_en = {WIDTH{drv_w}};
    assign driving  = drv_w;
endmodule

// File: rtl/xcvr_section.sv
module xcvr_section #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic [WIDTH-1:0] a_oe,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic [WIDTH-1:0] b_oe,
    input  logic             ab_chip_en_n,
    input  logic             ab_latch_en_n,
    input  logic             ab_out_en_n,
    input  logic             ba_chip_en_n,
    input  logic             ba_latch_en_n,
    input  logic             ba_out_en_n,
    output logic             contention
);
    logic ab_drv, ba_drv;

    xcvr_lane #(.WIDTH(WIDTH)) u_ab (
        .clk        (clk),
        .rst_n      (rst_n),
        .din        (a_in),
        .chip_en_n  (ab_chip_en_n),
        .latch_en_n (ab_latch_en_n),
        .out_en_n   (ab_out_en_n),
        .dout       (b_out),
        .drive_en   (b_oe),
        .driving    (ab_drv)
    );

    xcvr_lane #(.WIDTH(WIDTH)) u_ba (
        .clk        (clk),
        .rst_n      (rst_n),
        .din        (b_in),
        .chip_en_n  (ba_chip_en_n),
        .latch_en_n (ba_latch_en_n),
        .out_en_n   (ba_out_en_n),
        .dout       (a_out),
        .drive_en   (a_oe),
        .driving    (ba_drv)
    );

    assign contention = ab_drv & ba_drv;
endmodule

// File: rtl/xcvr_latched.sv
module xcvr_latched
    import xcvr_pkg::*;
#(
    parameter int unsigned SW = SECT_BITS,
    parameter int unsigned NS = SECTIONS,
    localparam int unsigned W = SW * NS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  a_in,
    output logic [W-1:0]  a_out,
    output logic [W-1:0]  a_oe,
    input  logic [W-1:0]  b_in,
    output logic [W-1:0]  b_out,
    output logic [W-1:0]  b_oe,
    input  logic [NS-1:0] ab_chip_en_n,
    input  logic [NS-1:0] ab_latch_en_n,
    input  logic [NS-1:0] ab_out_en_n,
    input  logic [NS-1:0] ba_chip_en_n,
    input  logic [NS-1:0] ba_latch_en_n,
    input  logic [NS-1:0] ba_out_en_n,
    output logic [NS-1:0] contention
);
    for (genvar k = 0; k < NS; k++) begin : g_sect
        xcvr_section #(.WIDTH(SW)) u_sect (
            .clk           (clk),
            .rst_n         (rst_n),
            .a_in          (a_in [k*SW +: SW]),
            .a_out         (a_out[k*SW +: SW]),
            .a_oe          (a_oe [k*SW +: SW]),
            .b_in          (b_in [k*SW +: SW]),
            .b_out         (b_out[k*SW +: SW]),
            .b_oe          (b_oe [k*SW +: SW]),
            .ab_chip_en_n  (ab_chip_en_n[k]),
            .ab_latch_en_n (ab_latch_en_n[k]),
            .ab_out_en_n   (ab_out_en_n[k]),
            .ba_chip_en_n  (ba_chip_en_n[k]),
            .ba_latch_en_n (ba_latch_en_n[k]),
            .ba_out_en_n   (ba_out_en_n[k]),
            .contention    (contention[k])
        );
    end
endmodule

// File: rtl/xcvr_latched_chk.sv
module xcvr_latched_chk #(
    parameter int unsigned SW = 8,
    parameter int unsigned NS = 2,
    localparam int unsigned W = SW * NS
) (
    input logic          clk,
    input logic          rst_n,
    input logic [W-1:0]  a_in,
    input logic [W-1:0]  a_out,
    input logic [W-1:0]  a_oe,
    input logic [W-1:0]  b_in,
    input logic [W-1:0]  b_out,
    input logic [W-1:0]  b_oe,
    input logic [NS-1:0] ab_chip_en_n,
    input logic [NS-1:0] ab_latch_en_n,
    input logic [NS-1:0] ab_out_en_n,
    input logic [NS-1:0] ba_chip_en_n,
    input logic [NS-1:0] ba_latch_en_n,
    input logic [NS-1:0] ba_out_en_n,
    input logic [NS-1:0] contention
);
    // R8
    undriven_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((b_out & ~b_oe) == '0) && ((a_out & ~a_oe) == '0));

    for (genvar k = 0; k < NS; k++) begin : g_chk
        // R3
        ab_transparent_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!ab_chip_en_n[k] && !ab_latch_en_n[k] && !ab_out_en_n[k])
            |-> (b_out[k*SW +: SW] == a_in[k*SW +: SW]));

        // R9
        ba_transparent_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!ba_chip_en_n[k] && !ba_latch_en_n[k] && !ba_out_en_n[k])
            |-> (a_out[k*SW +: SW] == b_in[k*SW +: SW]));

        // R4
        ab_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ab_latch_en_n[k] && !ab_chip_en_n[k] && !ab_out_en_n[k])
            ##1 (ab_latch_en_n[k] && !ab_chip_en_n[k] && !ab_out_en_n[k])
            |-> $stable(b_out[k*SW +: SW]));

        // R2
        ab_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ab_chip_en_n[k] |-> (b_oe[k*SW +: SW] == '0));

        // R10
        contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
            contention[k] |-> ((|a_oe[k*SW +: SW]) && (|b_oe[k*SW +: SW])));
    end
endmodule

bind xcvr_latched xcvr_latched_chk #(.SW(SW), .NS(NS)) u_chk (.*);

// File: tb/xcvr_latched_test.sv
module xcvr_latched_test;
    localparam int unsigned CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] a_in, b_in;
    logic [15:0] a_out, a_oe, b_out, b_oe;
    logic [1:0]  ab_ce, ab_le, ab_oe, ba_ce, ba_le, ba_oe;
    logic [1:0]  contention;
    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xcvr_latched uut (
        .clk(clk), .rst_n(rst_n),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
        .ab_chip_en_n(ab_ce), .ab_latch_en_n(ab_le), .ab_out_en_n(ab_oe),
        .ba_chip_en_n(ba_ce), .ba_latch_en_n(ba_le), .ba_out_en_n(ba_oe),
        .contention(contention)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one clock edge, then back to just after the falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        a_in = '0; b_in = '0;
        ab_ce = 2'b11; ab_le = 2'b11; ab_oe = 2'b11;
        ba_ce = 2'b11; ba_le = 2'b11; ba_oe = 2'b11;
        step(); step();
        settle();
        check("R2 reset b_oe", b_oe, 16'h0000);
        check("R9 reset a_oe", a_oe, 16'h0000);
        check("R10 reset contention", {14'd0, contention}, 16'h0000);
        rst_n = 1'b1;
        step();
        ab_ce = 2'b00; ab_oe = 2'b00;
        settle();
        check("R11 cleared store", b_out, 16'h0000);
        check("R2 drive enabled", b_oe, 16'hFFFF);
    endtask

    task automatic t_transparent_capture();
        ab_le = 2'b00; a_in = 16'h3C5A;
        settle();
        check("R3 follows", b_out, 16'h3C5A);
        a_in = 16'h1234;
        settle();
        check("R3 follows change", b_out, 16'h1234);
        step();
        ab_le = 2'b11; a_in = 16'hFFFF;
        settle();
        check("R4 held after close", b_out, 16'h1234);
        step();
        check("R4 still held", b_out, 16'h1234);
    endtask

    task automatic t_chip_close();
        ab_le = 2'b00; a_in = 16'hAAAA;
        step();
        ab_ce = 2'b11; a_in = 16'h5555;
        settle();
        check("R2 ce high b_oe", b_oe, 16'h0000);
        check("R8 undriven zero", b_out, 16'h0000);
        step();
        ab_ce = 2'b00; ab_le = 2'b11;
        settle();
        check("R5 R7 held through ce", b_out, 16'hAAAA);
    endtask

    task automatic t_sections();
        ab_le = 2'b10; a_in = 16'h9966;
        settle();
        check("R1 mixed sections", b_out, 16'hAA66);
        step();
        ab_le = 2'b11; ab_oe = 2'b10; a_in = 16'h0000;
        settle();
        check("R1 per section oe", b_oe, 16'h00FF);
        check("R1 per section data", b_out, 16'h0066);
    endtask

    task automatic t_oe_capture();
        ab_oe = 2'b11; ab_le = 2'b00; a_in = 16'h0F0F;
        settle();
        check("R6 not driven", b_out, 16'h0000);
        check("R6 oe off", b_oe, 16'h0000);
        step();
        ab_le = 2'b11; ab_oe = 2'b00; a_in = 16'h0000;
        settle();
        check("R6 captured while off", b_out, 16'h0F0F);
    endtask

    task automatic t_reverse();
        ab_ce = 2'b11;
        ba_ce = 2'b00; ba_le = 2'b00; ba_oe = 2'b00; b_in = 16'hC3C3;
        settle();
        check("R9 follows", a_out, 16'hC3C3);
        check("R9 a_oe", a_oe, 16'hFFFF);
        check("R10 one way", {14'd0, contention}, 16'h0000);
        step();
        ba_le = 2'b11; b_in = 16'h0000;
        settle();
        check("R9 held", a_out, 16'hC3C3);
        check("R9 b side intact", b_out, 16'h0000);
    endtask

    task automatic t_contention();
        ab_ce = 2'b00; ab_oe = 2'b00;
        settle();
        check("R10 both sections", {14'd0, contention}, 16'h0003);
        ab_oe = 2'b01;
        settle();
        check("R10 section one only", {14'd0, contention}, 16'h0002);
        check("R9 reverse held under contention", a_out, 16'hC3C3);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_transparent_capture();
        t_chip_close();
        t_sections();
        t_oe_capture();
        t_reverse();
        t_contention();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule